// File: doc/BRIEF.md
# Landing Pad Enforcement Unit

This block guards forward-edge control flow on a RISC-V hart. It watches the instruction stream at retirement and keeps a one-bit "landing pad expected" flag. An indirect call or jump whose base register is not x1, x5 or x7 arms the flag. The next retired instruction must then be a 4-byte-aligned landing pad. That pad's 20-bit label must be zero or equal to bits 31:12 of x7. When this check fails, the block reports a software-check exception. When it succeeds, the flag is cleared.

The surrounding pipeline presents each retiring instruction on a valid strobe. It supplies the raw encoding, with 16-bit compressed forms in the low half, along with the two low PC bits and the upper twenty bits of x7. A per-privilege enable is taken as an input. The exception appears as a one-cycle pulse with cause and trap-value code, one cycle after the retire that triggers it. The state machine has two states. IDLE means no pad is expected. ARMED means a pad is expected. ARM_XFER is the transition IDLE to ARMED. PAD_OK is the transition ARMED to IDLE. PAD_FAIL is the self-loop on ARMED, and it raises the fault.

Top module: `lpad_guard`

## Requirements
- R1: After reset the flag reads 0 (IDLE) and no fault is signalled.
- R2: With the enable high, a retired indirect transfer whose base register is not x1, x5 or x7 sets the flag on the following cycle. The indirect transfers are JALR (opcode bits 6:0 = 1100111, bits 14:12 = 000, base in bits 19:15), C.JR and C.JALR.
- R3: An indirect transfer whose base register is x1, x5 or x7 never sets the flag.
- R4: C.JR is recognised by bits 1:0 = 10, bits 15:12 = 1000, a nonzero base in bits 11:7 and zero in bits 6:2. C.JALR uses the same fields with bits 15:12 = 1001.
- R5: A landing pad has opcode bits 6:0 = 0010111, bits 11:7 = 0 and its label in bits 31:12. While ARMED, a retired pad with PC bits 1:0 = 00 clears the flag and raises no fault, provided its label is zero or equals x7[31:12].
- R6: While ARMED, a retired instruction raises a fault if it is misaligned, or is not a pad, or carries a nonzero label that differs from x7[31:12]. The fault appears the cycle after the retire with cause 18 and trap-value code 2. The flag stays set.
- R7: The fault pulse lasts one cycle. Cause and code read 0 whenever no fault is signalled.
- R8: With the enable low, a retire neither arms nor checks. No fault is raised, and the flag keeps its value.
- R9: A landing pad retired while IDLE is a no-op whatever its alignment or label.
- R10: Cycles without the retire strobe change neither the flag nor the fault output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_valid | input | 1 | Retire strobe |
| rt_insn | input | 32 | Retiring encoding (compressed forms in bits 15:0) |
| rt_pc_lo | input | 2 | Bits 1:0 of the retiring PC |
| x7_hi | input | 20 | Bits 31:12 of register x7 |
| lp_enable | input | 1 | Landing-pad checking enabled for current privilege |
| lp_expect | output | 1 | Expectation flag (1 = ARMED) |
| sw_fault | output | 1 | Software-check exception pulse |
| sw_cause | output | 6 | Exception cause (18 when faulting) |
| sw_tval | output | 4 | Trap-value code (2 when faulting) |

## Verification
The bound checker watches several properties on every cycle. It checks that a fault always carries cause 18 and code 2 and leaves the flag set. It checks that faults and flag rises only follow an enabled retire. It checks that disabled or idle cycles leave the flag and fault quiet. Only the directed scenarios can show the encoding-dependent outcomes. These are which base registers arm the flag and the decode of the compressed forms. They also cover label matching, the zero-label bypass, the alignment rule, and the pad being a no-op while IDLE.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    localparam int LABEL_W = 20;
    localparam int CAUSE_W = 6;
    localparam int TVAL_W  = 4;
    localparam int RIDX_W  = 5;
    localparam logic [CAUSE_W-1:0] SWCHK_CAUSE = CAUSE_W'(18);
    localparam logic [TVAL_W-1:0]  LPAD_CODE   = TVAL_W'(2);

    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;
    localparam logic [3:0] C_F4_JR   = 4'b1000;
    localparam logic [3:0] C_F4_JALR = 4'b1001;

    typedef enum logic {
        LPG_IDLE  = 1'b0,
        LPG_ARMED = 1'b1
    } lpg_state_e;
endpackage

// File: rtl/lpg_decode.sv
module lpg_decode
    import lpg_pkg::*;
(
    input  logic [31:0]        insn,
    output logic               arm_cand,
    output logic               is_pad,
    output logic [LABEL_W-1:0] pad_label
);
    logic               wide;
    logic               jalr32;
    logic               cjump;
    logic [RIDX_W-1:0]  base;
    logic               guarded;

    always_comb begin
        wide   = (insn[1:0] == 2'b11);
        jalr32 = wide && (insn[6:0] == OPC_JALR) && (insn[14:12] == 3'b000);
        cjump  = !wide && (insn[1:0] == 2'b10)
                 && ((insn[15:12] == C_F4_JR) || (insn[15:12] == C_F4_JALR))
                 && (insn[11:7] != '0) && (insn[6:2] == '0);
        base   = wide ? insn[19:15] : insn[11:7];
        guarded = (base == RIDX_W'(1)) || (base == RIDX_W'(5)) || (base == RIDX_W'(7));
        arm_cand  = (jalr32 || cjump) && !guarded;
        is_pad    = wide && (insn[6:0] == OPC_AUIPC) && (insn[11:7] == '0);
        pad_label = insn[31:12];
    end
endmodule

// File: rtl/lpg_check.sv
module lpg_check
    import lpg_pkg::*;
(
    input  logic               is_pad,
    input  logic [LABEL_W-1:0] pad_label,
    input  logic [LABEL_W-1:0] x7_hi,
    input  logic [1:0]         pc_lo,
    output logic               pad_ok
);
    logic aligned;
    logic label_ok;

    always_comb begin
        aligned  = (pc_lo == 2'b00);
        label_ok = (pad_label == '0) || (pad_label == x7_hi);
        pad_ok   = is_pad && aligned && label_ok;
    end
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
    import lpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rt_valid,
    input  logic [31:0]        rt_insn,
    input  logic [1:0]         rt_pc_lo,
    input  logic [LABEL_W-1:0] x7_hi,
    input  logic               lp_enable,
    output logic               lp_expect,
    output logic               sw_fault,
    output logic [CAUSE_W-1:0] sw_cause,
    output logic [TVAL_W-1:0]  sw_tval
);
    lpg_state_e         state_q, state_d;
    logic               fault_q, fault_d;
    logic               arm_cand;
    logic               is_pad;
    logic [LABEL_W-1:0] pad_label;
    logic               pad_ok;
    logic               act;

    lpg_decode u_dec (
        .insn      (rt_insn),
        .arm_cand  (arm_cand),
        .is_pad    (is_pad),
        .pad_label (pad_label)
    );

    lpg_check u_chk (
        .is_pad    (is_pad),
        .pad_label (pad_label),
        .x7_hi     (x7_hi),
        .pc_lo     (rt_pc_lo),
        .pad_ok    (pad_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LPG_IDLE;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    // Transitions: ARM_XFER, PAD_OK, PAD_FAIL
    always_comb begin
        act     = rt_valid && lp_enable;
        state_d = state_q;
        fault_d = 1'b0;
        unique case (state_q)
            LPG_IDLE: begin
                if (act && arm_cand) state_d = LPG_ARMED;
            end
            LPG_ARMED: begin
                if (act) begin
                    if (pad_ok) state_d = LPG_IDLE;
                    else        fault_d = 1'b1;
                end
            end
            default: state_d = LPG_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        lp_expect = (state_q == LPG_ARMED);
        sw_fault  = fault_q;
        sw_cause  = fault_q ? SWCHK_CAUSE : '0;
        sw_tval   = fault_q ? LPAD_CODE   : '0;
    end
endmodule

// File: rtl/lpad_guard_sva.sv
module lpad_guard_sva
    import lpg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rt_valid,
    input logic               lp_enable,
    input logic               lp_expect,
    input logic               sw_fault,
    input logic [CAUSE_W-1:0] sw_cause,
    input logic [TVAL_W-1:0]  sw_tval
);
    assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fault |-> (sw_cause == SWCHK_CAUSE && sw_tval == LPAD_CODE && lp_expect));

    assert_quiet_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_fault |-> (sw_cause == '0 && sw_tval == '0));

    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && !lp_enable) |=> ($stable(lp_expect) && !sw_fault));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_valid |=> ($stable(lp_expect) && !sw_fault));

    assert_arm_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_expect) |-> $past(rt_valid && lp_enable));
endmodule

bind lpad_guard lpad_guard_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rt_valid  (rt_valid),
    .lp_enable (lp_enable),
    .lp_expect (lp_expect),
    .sw_fault  (sw_fault),
    .sw_cause  (sw_cause),
    .sw_tval   (sw_tval)
);

// File: tb/tb_lpad_guard.sv
module tb_lpad_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rt_valid = 1'b0;
    logic [31:0] rt_insn = 32'h0000_0013;
    logic [1:0]  rt_pc_lo = 2'b00;
    logic [19:0] x7_hi = 20'h0;
    logic        lp_enable = 1'b1;
    logic        lp_expect;
    logic        sw_fault;
    logic [5:0]  sw_cause;
    logic [3:0]  sw_tval;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpad_guard dut (
        .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_insn(rt_insn),
        .rt_pc_lo(rt_pc_lo), .x7_hi(x7_hi), .lp_enable(lp_enable),
        .lp_expect(lp_expect), .sw_fault(sw_fault), .sw_cause(sw_cause),
        .sw_tval(sw_tval)
    );

    localparam logic [31:0] NOP = 32'h0000_0013;

    function automatic logic [31:0] jalr(input logic [4:0] rd, input logic [4:0] rs1);
        return {12'h000, rs1, 3'b000, rd, 7'b1100111};
    endfunction
    function automatic logic [31:0] cjr(input logic [4:0] rs1);
        return {16'h0000, 4'b1000, rs1, 5'b00000, 2'b10};
    endfunction
    function automatic logic [31:0] cjalr(input logic [4:0] rs1);
        return {16'h0000, 4'b1001, rs1, 5'b00000, 2'b10};
    endfunction
    function automatic logic [31:0] lpad(input logic [19:0] lbl);
        return {lbl, 5'b00000, 7'b0010111};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one retire at a negedge; return at the following negedge.
    task automatic retire(input logic [31:0] insn, input logic [1:0] pc, input logic [19:0] lbl, input logic en);
        rt_insn = insn; rt_pc_lo = pc; x7_hi = lbl; lp_enable = en; rt_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rt_valid = 1'b0; rt_insn = NOP; lp_enable = 1'b1;
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_state(input string req, input logic e, input logic f);
        chk(req, "lp_expect", {31'b0, lp_expect}, {31'b0, e});
        chk(req, "sw_fault", {31'b0, sw_fault}, {31'b0, f});
        chk(req, "sw_cause", {26'b0, sw_cause}, f ? 32'd18 : 32'd0);
        chk(req, "sw_tval", {28'b0, sw_tval}, f ? 32'd2 : 32'd0);
    endtask

    task automatic clear_armed();
        retire(lpad(20'h0), 2'b00, 20'h0, 1'b1);
    endtask

    task automatic t_reset();
        expect_state("R1", 1'b0, 1'b0);
    endtask

    task automatic t_arm_jalr();
        retire(jalr(5'd0, 5'd10), 2'b00, 20'h0, 1'b1);
        expect_state("R2", 1'b1, 1'b0);
        retire(lpad(20'h0), 2'b00, 20'h0, 1'b1);
        expect_state("R5", 1'b0, 1'b0);
    endtask

    task automatic t_guarded();
        retire(jalr(5'd0, 5'd1), 2'b00, 20'h0, 1'b1);
        expect_state("R3", 1'b0, 1'b0);
        retire(jalr(5'd1, 5'd5), 2'b00, 20'h0, 1'b1);
        expect_state("R3", 1'b0, 1'b0);
        retire(jalr(5'd0, 5'd7), 2'b00, 20'h0, 1'b1);
        expect_state("R3", 1'b0, 1'b0);
        retire(cjr(5'd1), 2'b00, 20'h0, 1'b1);
        expect_state("R3", 1'b0, 1'b0);
        retire(cjalr(5'd7), 2'b00, 20'h0, 1'b1);
        expect_state("R3", 1'b0, 1'b0);
    endtask

    task automatic t_compressed();
        retire(cjr(5'd12), 2'b10, 20'h0, 1'b1);
        expect_state("R4", 1'b1, 1'b0);
        clear_armed();
        retire(cjalr(5'd6), 2'b10, 20'h0, 1'b1);
        expect_state("R4", 1'b1, 1'b0);
        clear_armed();
        // rs2 nonzero (a register add): not a jump
        retire({16'h0, 4'b1000, 5'd12, 5'd3, 2'b10}, 2'b00, 20'h0, 1'b1);
        expect_state("R4", 1'b0, 1'b0);
        // JALR opcode with funct3 nonzero is not a jump
        retire({12'h0, 5'd10, 3'b001, 5'd0, 7'b1100111}, 2'b00, 20'h0, 1'b1);
        expect_state("R4", 1'b0, 1'b0);
    endtask

    task automatic t_label_match();
        retire(jalr(5'd1, 5'd11), 2'b00, 20'h0, 1'b1);
        retire(lpad(20'hABCDE), 2'b00, 20'hABCDE, 1'b1);
        expect_state("R5", 1'b0, 1'b0);
        retire(jalr(5'd1, 5'd11), 2'b00, 20'h0, 1'b1);
        retire(lpad(20'h0), 2'b00, 20'h12345, 1'b1);
        expect_state("R5", 1'b0, 1'b0);
    endtask

    task automatic t_faults();
        retire(jalr(5'd0, 5'd10), 2'b00, 20'h0, 1'b1);
        retire(lpad(20'h0), 2'b10, 20'h0, 1'b1);
        expect_state("R6", 1'b1, 1'b1);
        idle_cycle();
        expect_state("R7", 1'b1, 1'b0);
        retire(NOP, 2'b00, 20'h0, 1'b1);
        expect_state("R6", 1'b1, 1'b1);
        retire(lpad(20'h00042), 2'b00, 20'h00043, 1'b1);
        expect_state("R6", 1'b1, 1'b1);
        retire(lpad(20'h00043), 2'b00, 20'h00043, 1'b1);
        expect_state("R7", 1'b0, 1'b0);
    endtask

    task automatic t_disabled();
        retire(jalr(5'd0, 5'd10), 2'b00, 20'h0, 1'b0);
        expect_state("R8", 1'b0, 1'b0);
        retire(jalr(5'd0, 5'd10), 2'b00, 20'h0, 1'b1);
        retire(NOP, 2'b01, 20'h0, 1'b0);
        expect_state("R8", 1'b1, 1'b0);
        retire(lpad(20'h0), 2'b00, 20'h0, 1'b0);
        expect_state("R8", 1'b1, 1'b0);
        clear_armed();
        expect_state("R8", 1'b0, 1'b0);
    endtask

    task automatic t_idle_pad();
        retire(lpad(20'h7777), 2'b10, 20'h1, 1'b1);
        expect_state("R9", 1'b0, 1'b0);
    endtask

    task automatic t_no_valid();
        retire(jalr(5'd0, 5'd10), 2'b00, 20'h0, 1'b1);
        rt_insn = NOP; rt_pc_lo = 2'b11;
        idle_cycle();
        idle_cycle();
        expect_state("R10", 1'b1, 1'b0);
        rt_pc_lo = 2'b00;
        clear_armed();
        rt_insn = jalr(5'd0, 5'd9);
        idle_cycle();
        expect_state("R10", 1'b0, 1'b0);
        rt_insn = NOP;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm_jalr();
        t_guarded();
        t_compressed();
        t_label_match();
        t_faults();
        t_disabled();
        t_idle_pad();
        t_no_valid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule